// File: doc/BRIEF.md
# Branch Target Address Calculator

This unit works out the destination of a branch or jump for one thread. An opcode kind selects the form. Relative forms add their operands to the offset of the following instruction. Absolute forms take the operand sum directly as the target offset. The operands are the current instruction offset, a register value, an immediate field and a constant-bank value that has already been fetched. Every quantity is counted in bytes.

Each operand is widened to its proper sign or zero extension, and the three terms are added without loss of precision. A result that falls outside the 0 to 4 GB window raises a range fault. An immediate whose two low bits are not clear raises an alignment fault. When neither fault is present, the 32-bit target offset is added to a 40-bit program base to give the final virtual address. All results appear one clock after the input strobe. Condition evaluation and fetch redirection are left to the surrounding logic.

Top module: `brtgt_calc`

## Requirements
- R1: `in_kind[2]` selects absolute (1) or relative (0). `in_kind[1:0]` selects the operand form: 0 is immediate only, 1 is constant operand, 2 is register plus immediate, and 3 is handled exactly like 0.
- R2: Relative forms take the next-instruction offset, `in_pc` + 8, as their base term. All offsets are in bytes.
- R3: The relative immediate-only form adds `in_imm[23:0]` sign-extended. Bits 31:24 of `in_imm` have no effect on the result.
- R4: The absolute immediate-only form uses `in_imm` as an unsigned 32-bit target offset.
- R5: The constant-operand form reads `in_const` as a signed 32-bit offset when relative and as an unsigned 32-bit target when absolute.
- R6: The relative register form adds `in_reg` as signed 32-bit and `in_imm[23:0]` as signed 24-bit.
- R7: The absolute register form adds `in_reg` as unsigned 32-bit and `in_imm` as signed 32-bit. The immediate stays signed even when `in_reg` is zero.
- R8: The sum is exact. A sum below 0, or at or above 2^32, sets `out_range_fault` and keeps `out_valid` low.
- R9: The forms that carry an immediate (form codes 0, 2 and 3) set `out_align_fault` when `in_imm[1:0]` is nonzero, and `out_valid` stays low. Constant operands and register low bits are not checked.
- R10: `out_addr` equals `in_base` plus the 32-bit target offset, modulo 2^40.
- R11: The outputs are registered one cycle after `in_valid`. With no strobe in the previous cycle, and during reset, `out_valid` and both fault outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 3 | Absolute flag and operand form |
| in_pc | input | 32 | Current instruction byte offset |
| in_reg | input | 32 | Register operand |
| in_imm | input | 32 | Immediate field |
| in_const | input | 32 | Constant-bank operand |
| in_base | input | 40 | Program base virtual address |
| out_valid | output | 1 | Target address is usable |
| out_addr | output | 40 | Final virtual target address |
| out_range_fault | output | 1 | Target offset is outside 0 to 4 GB |
| out_align_fault | output | 1 | Immediate low bits are not zero |

## Verification
The assertions check four things on every cycle:
- a fault and a valid target are never reported together;
- the outputs stay quiet when there was no strobe;
- a misaligned immediate always produces an alignment fault;
- the absolute immediate form places its immediate on top of the base.

Only the bench's scenarios can show the signed and unsigned readings of each operand, the next-instruction bias, and the exact edges of the 4 GB window (targets of -4, 0, 2^32-4 and 2^32). The same holds for the address wrap at 2^40. The bench's reference model computes these with plain 64-bit integers.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [1:0] {
    FORM_IMM   = 2'd0,
    FORM_CONST = 2'd1,
    FORM_REG   = 2'd2,
    FORM_ALT   = 2'd3
  } form_e;
endpackage

// File: rtl/brtgt_operand.sv
module brtgt_operand
  import brtgt_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int IMM_S_W = 24,
  parameter int SUM_W   = 36,
  parameter int PC_STEP = 8
) (
  input  logic [KIND_W-1:0]       kind,
  input  logic [OFF_W-1:0]        pc,
  input  logic [OFF_W-1:0]        rval,
  input  logic [OFF_W-1:0]        imm,
  input  logic [OFF_W-1:0]        cval,
  output logic signed [SUM_W-1:0] base_term,
  output logic signed [SUM_W-1:0] opnd_term,
  output logic signed [SUM_W-1:0] imm_term,
  output logic                    imm_used
);
  localparam int PAD_FULL  = SUM_W - OFF_W;
  localparam int PAD_SHORT = SUM_W - IMM_S_W;

  function automatic logic signed [SUM_W-1:0] widen_u(input logic [OFF_W-1:0] v);
    return {{PAD_FULL{1'b0}}, v};
  endfunction

  function automatic logic signed [SUM_W-1:0] widen_s(input logic [OFF_W-1:0] v);
    return {{PAD_FULL{v[OFF_W-1]}}, v};
  endfunction

  function automatic logic signed [SUM_W-1:0] widen_short(input logic [OFF_W-1:0] v);
    return {{PAD_SHORT{v[IMM_S_W-1]}}, v[IMM_S_W-1:0]};
  endfunction

  logic  absolute;
  form_e form;

  assign absolute = kind[KIND_W-1];
  assign form     = form_e'(kind[1:0]);

  always_comb begin
    base_term = absolute ? '0 : widen_u(pc) + SUM_W'(PC_STEP);
    opnd_term = '0;
    imm_term  = '0;
    imm_used  = 1'b1;
    unique case (form)
      FORM_CONST: begin
        opnd_term = absolute ? widen_u(cval) : widen_s(cval);
        imm_used  = 1'b0;
      end
      FORM_REG: begin
        opnd_term = absolute ? widen_u(rval) : widen_s(rval);
        imm_term  = absolute ? widen_s(imm)  : widen_short(imm);
      end
      default: begin
        imm_term  = absolute ? widen_u(imm)  : widen_short(imm);
      end
    endcase
  end
endmodule

// File: rtl/brtgt_sum.sv
module brtgt_sum #(
  parameter int OFF_W = 32,
  parameter int SUM_W = 36
) (
  input  logic signed [SUM_W-1:0] term_a,
  input  logic signed [SUM_W-1:0] term_b,
  input  logic signed [SUM_W-1:0] term_c,
  output logic [OFF_W-1:0]        target,
  output logic                    over_range
);
  logic signed [SUM_W-1:0] exact_sum;

  assign exact_sum  = term_a + term_b + term_c;
  assign target     = exact_sum[OFF_W-1:0];
  // negative results carry set upper bits, so one test covers both edges
  assign over_range = |exact_sum[SUM_W-1:OFF_W];
endmodule

// File: rtl/brtgt_calc.sv
module brtgt_calc
  import brtgt_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int BASE_W  = 40,
  parameter int IMM_S_W = 24,
  parameter int PC_STEP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [KIND_W-1:0]    in_kind,
  input  logic [OFF_W-1:0]     in_pc,
  input  logic [OFF_W-1:0]     in_reg,
  input  logic [OFF_W-1:0]     in_imm,
  input  logic [OFF_W-1:0]     in_const,
  input  logic [BASE_W-1:0]    in_base,
  output logic                 out_valid,
  output logic [BASE_W-1:0]    out_addr,
  output logic                 out_range_fault,
  output logic                 out_align_fault
);
  localparam int SUM_W = OFF_W + 4;

  logic signed [SUM_W-1:0] base_term;
  logic signed [SUM_W-1:0] opnd_term;
  logic signed [SUM_W-1:0] imm_term;
  logic                    imm_used;
  logic [OFF_W-1:0]        calc_target;
  logic                    calc_range_fault;
  logic                    calc_align_fault;
  logic                    calc_ok;
  logic [BASE_W-1:0]       calc_addr;

  brtgt_operand #(
    .OFF_W(OFF_W), .IMM_S_W(IMM_S_W), .SUM_W(SUM_W), .PC_STEP(PC_STEP)
  ) u_operand (
    .kind(in_kind), .pc(in_pc), .rval(in_reg), .imm(in_imm), .cval(in_const),
    .base_term(base_term), .opnd_term(opnd_term), .imm_term(imm_term),
    .imm_used(imm_used)
  );

  brtgt_sum #(.OFF_W(OFF_W), .SUM_W(SUM_W)) u_sum (
    .term_a(base_term), .term_b(opnd_term), .term_c(imm_term),
    .target(calc_target), .over_range(calc_range_fault)
  );

  assign calc_align_fault = imm_used && (in_imm[1:0] != 2'b00);
  assign calc_ok          = !calc_range_fault && !calc_align_fault;
  assign calc_addr        = in_base + BASE_W'(calc_target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_range_fault <= 1'b0;
      out_align_fault <= 1'b0;
      out_addr        <= '0;
    end else begin
      out_valid       <= in_valid && calc_ok;
      out_range_fault <= in_valid && calc_range_fault;
      out_align_fault <= in_valid && calc_align_fault;
      if (in_valid) out_addr <= calc_addr;
    end
  end

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !out_valid && !out_range_fault && !out_align_fault);

  a_r8_valid_excludes_fault: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_range_fault && !out_align_fault);

  a_r9_misaligned_imm: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_kind[1:0] != 2'd1 && in_imm[1:0] != 2'b00)
      |-> out_align_fault && !out_valid);

  a_r4_abs_imm_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_kind == 3'b100 && in_imm[1:0] == 2'b00)
      |-> out_valid && out_addr == $past(in_base + BASE_W'(in_imm)));
endmodule

// File: tb/brtgt_calc_bench.sv
module brtgt_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_kind = '0;
  logic [31:0] in_pc = '0, in_reg = '0, in_imm = '0, in_const = '0;
  logic [39:0] in_base = '0;
  logic        out_valid, out_range_fault, out_align_fault;
  logic [39:0] out_addr;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    checking = 1'b0;
  string cur_tag = "R11";

  bit          e_v, e_rf, e_af;
  logic [39:0] e_a;
  string       e_tag = "R11";

  always #2 clk = ~clk;

  brtgt_calc u_brtgt_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_pc(in_pc), .in_reg(in_reg), .in_imm(in_imm), .in_const(in_const),
    .in_base(in_base), .out_valid(out_valid), .out_addr(out_addr),
    .out_range_fault(out_range_fault), .out_align_fault(out_align_fault)
  );

  function automatic longint as_u(input logic [31:0] x);
    return longint'(x);
  endfunction
  function automatic longint as_s32(input logic [31:0] x);
    longint r = longint'(x);
    if (x[31]) r = r - 64'sd4294967296;
    return r;
  endfunction
  function automatic longint as_s24(input logic [31:0] x);
    longint r = longint'(x[23:0]);
    if (x[23]) r = r - 64'sd16777216;
    return r;
  endfunction

  // behavioural reference: exact integer arithmetic per requirement
  always @(posedge clk) begin
    longint t;
    bit ab;
    if (!rst_n || !in_valid) begin
      e_v = 0; e_rf = 0; e_af = 0;
    end else begin
      ab = in_kind[2];
      t  = ab ? 64'sd0 : as_u(in_pc) + 8;                       // R2
      case (in_kind[1:0])
        2'd1: t = t + (ab ? as_u(in_const) : as_s32(in_const)); // R5
        2'd2: t = t + (ab ? as_u(in_reg) : as_s32(in_reg))      // R6 R7
                    + (ab ? as_s32(in_imm) : as_s24(in_imm));
        default: t = t + (ab ? as_u(in_imm) : as_s24(in_imm));  // R3 R4 R1
      endcase
      e_rf = (t < 0) || (t >= 64'sd4294967296);                  // R8
      e_af = (in_kind[1:0] != 2'd1) && (in_imm[1:0] != 2'b00);  // R9
      e_v  = !e_rf && !e_af;
      if (e_v) e_a = in_base + {8'h00, t[31:0]};                 // R10
    end
    e_tag = cur_tag;
  end

  always @(negedge clk) begin
    if (checking) begin
      n_tests++;
      if (out_valid !== e_v || out_range_fault !== e_rf || out_align_fault !== e_af ||
          (e_v && out_addr !== e_a)) begin
        n_fail++;
        $display("FAIL %s: got v=%0b rf=%0b af=%0b addr=%h, expected v=%0b rf=%0b af=%0b addr=%h",
                 e_tag, out_valid, out_range_fault, out_align_fault, out_addr,
                 e_v, e_rf, e_af, e_a);
      end
    end
  end

  task automatic issue(input string tag, input logic [2:0] k, input logic [31:0] pc,
                       input logic [31:0] rg, input logic [31:0] im,
                       input logic [31:0] cs, input logic [39:0] bs);
    cur_tag = tag;
    in_kind = k; in_pc = pc; in_reg = rg; in_imm = im; in_const = cs; in_base = bs;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_tests++;
    if (out_valid !== 0 || out_range_fault !== 0 || out_align_fault !== 0 || out_addr !== 0) begin
      n_fail++;
      $display("FAIL R11: reset outputs v=%0b rf=%0b af=%0b addr=%h, expected all zero",
               out_valid, out_range_fault, out_align_fault, out_addr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checking = 1'b1;
    // R2/R3: relative immediate, next-instruction base, upper bits ignored
    issue("R2", 3'b000, 32'h100, 0, 32'h0000_0040, 0, 40'h10_0000_0000);
    issue("R3", 3'b000, 32'h100, 0, 32'hAB00_0040, 0, 40'h10_0000_0000);
    issue("R3", 3'b000, 32'h1000, 0, 32'h00FF_FF00, 0, 40'h0);
    issue("R8", 3'b000, 32'h0, 0, 32'h00FF_FFF8, 0, 40'h5);          // target 0
    issue("R8", 3'b000, 32'h0, 0, 32'h00FF_FFF4, 0, 40'h5);          // target -4
    issue("R8", 3'b000, 32'hFFFF_FFF0, 0, 32'h4, 0, 40'h0);          // 2^32-4
    issue("R8", 3'b000, 32'hFFFF_FFF8, 0, 32'h0, 0, 40'h0);          // 2^32
    // R4 absolute immediate
    issue("R4", 3'b100, 32'h1234, 0, 32'hFFFF_FFFC, 0, 40'h80_0000_0000);
    issue("R1", 3'b111, 32'h1234, 0, 32'h0000_0800, 0, 40'h1);
    issue("R1", 3'b011, 32'h20, 0, 32'h00FF_FFE0, 0, 40'h1);
    // R5 constant operand, low bits not checked
    issue("R5", 3'b001, 32'h400, 0, 32'h3, 32'hFFFF_FF00, 40'h0);
    issue("R5", 3'b101, 32'h400, 0, 32'h3, 32'hFFFF_FFFF, 40'h0);
    issue("R5", 3'b001, 32'h10, 0, 0, 32'h8000_0000, 40'h0);
    // R6 relative register
    issue("R6", 3'b010, 32'h200, 32'hFFFF_FFF0, 32'h00FF_FFFC, 0, 40'h0);
    issue("R6", 3'b010, 32'h0, 32'h0000_0003, 32'h4, 0, 40'h0);      // odd reg ok
    // R7 absolute register, signed immediate with zero register
    issue("R7", 3'b110, 0, 32'h0, 32'hFFFF_FFFC, 0, 40'h0);
    issue("R7", 3'b110, 0, 32'h100, 32'hFFFF_FFFC, 0, 40'h0);
    issue("R7", 3'b110, 0, 32'hFFFF_FFFF, 32'h4, 0, 40'h0);
    issue("R7", 3'b110, 0, 32'hFFFF_FFFC, 32'h0, 0, 40'h0);
    // R9 alignment, alone and combined with range
    issue("R9", 3'b000, 32'h0, 0, 32'h2, 0, 40'h0);
    issue("R9", 3'b110, 0, 32'hFFFF_FFFF, 32'h7FFF_FFF1, 0, 40'h0);
    // R10 address wrap
    issue("R10", 3'b100, 0, 0, 32'h200, 0, 40'hFF_FFFF_FF00);
    // R11 idle cycles
    cur_tag = "R11";
    repeat (3) @(negedge clk);
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, c, d;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; c = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; d = seed;
      if (d[5:4] != 2'b00) c[1:0] = 2'b00;
      if (d[7]) b = b >> d[12:8];
      issue("R10", d[2:0], a & 32'hFFFF_FFFC, b, c, a ^ b, {d[31:24], a});
      if (d[3]) @(negedge clk);
    end
    @(negedge clk);
    checking = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule